// File: doc/BRIEF.md
# Three-Channel Soft-Stepping Volume Stage

This block applies a digital gain to a stream of three-channel audio frames. Software writes one master attenuation register and one gain register per channel. The block adds the two settings into a single attenuation index for each channel, which counts in 0.5 dB units below +48 dB. The applied index moves toward that target one 0.5 dB step at a time. Steps happen at a rate tied to the sample stream, so that a volume change does not click. The ramp can be turned off so that the gain jumps at once. A per-channel bypass also makes the gain jump.

Mutes exist at two levels, master and channel, and each level has two kinds. A hard mute drops the gain to the mute index at once. A soft mute ramps the gain down to the mute index. An optional zero-run detector mutes a channel after its input has stayed at zero for a set number of frames. The applied index is an output, and it also addresses an external dB-to-linear coefficient lookup. The block multiplies each accepted sample by the looked-up coefficient and saturates the result. When the index is the mute index, the output sample is forced to zero.

Frames enter and leave on valid/ready streams through a single output register. A frame is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high while the output register is empty or is being drained in the same cycle. A stalled output holds its frame unchanged until `out_ready` rises.

Top module: `svol_top`

## Requirements
- R1: The register map is as follows. Address 0 holds the master volume. Address 1 holds master control: bit0 hard mute, bit1 soft mute, bit2 soft-ramp enable, bit3 zero-run mute enable. Address 2+c holds the volume of channel c. Address 2+NCH+c holds the control of channel c: bit0 hard mute, bit1 soft mute, bit2 bypass. After reset, master volume is 0x00, master control is 0x04, every channel volume is 0x60 and every channel control is 0x00.
- R2: Master code m means -0.5·m dB. Channel code v means +48 dB − 0.5·v dB. The target index is m+v, saturated at 255 (0xFF, the mute index). Soft mute at either level makes the target 255.
- R3: While soft ramping is enabled, bypass is clear and no hard mute is active, the applied index moves by exactly one toward the target on every STEP_DIV-th accepted frame (counting all frames since reset). It holds between those frames, so the ramp is monotonic and ends exactly on the target.
- R4: When soft ramping is disabled, or the channel's bypass bit is set, the applied index equals the target one clock after the registers change. With bypass set, the target is 96 (0 dB) and both volume codes are ignored.
- R5: A hard mute at master or channel level sets the applied index to 255 on the next clock, even with soft ramping enabled. After release, the index ramps up from 255.
- R6: A soft mute ramps the applied index down to 255. Any frame accepted while a channel's index is 255 produces 0 on that channel.
- R7: With zero-run mute enabled, a channel whose last ZD_LEN accepted samples were all zero is hard-muted. The next nonzero sample on that channel ends the mute, and that sample itself is output as 0.
- R8: The gain index output, 8 bits per channel with channel c in bits [8c+7:8c], addresses the coefficient lookup. The output sample is (sample × coefficient) >> COEF_FRAC, using an arithmetic shift and saturation to the signed sample range. The coefficient is unsigned.
- R9: A frame is accepted when in_valid and in_ready are both high. in_ready equals !out_valid || out_ready. While out_valid is high and out_ready is low, out_valid and out_data hold. Frames leave in the order they were accepted.
- R10: During and right after reset, every applied index is 255 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| in_valid | input | 1 | Input frame valid |
| in_ready | output | 1 | Input frame ready |
| in_data | input | NCH*SAMPLE_W | Input frame; channel c in slice c |
| out_valid | output | 1 | Output frame valid |
| out_ready | input | 1 | Output frame ready |
| out_data | output | NCH*SAMPLE_W | Scaled output frame |
| gain_idx | output | NCH*8 | Applied attenuation index per channel, lookup address |
| lut_coef | input | NCH*COEF_W | Linear coefficient per channel for the current gain_idx |

## Verification
The bench follows the power-up ramp from the mute index down to 0 dB frame by frame. A design that stepped on every frame, or jumped straight to the target, would fail the per-frame index comparison. It checks the master-plus-channel sum where it overflows past 255, where a wrapping adder would unmute the channel. It checks that a hard mute beats an active ramp, and that the last step of a soft mute reaches 255 and forces zero output even though the lookup coefficient there is nonzero. It also checks that the zero-run mute engages on exactly the ZD_LEN-th zero and that the releasing sample comes out as zero. Finally, it stalls the output and confirms the held frame stays unchanged and that two frames are not swapped or lost.

// File: rtl/svol_pkg.sv
package svol_pkg;

  localparam int GAIN_W = 8;
  typedef logic [GAIN_W-1:0] gain_t;

  // attenuation index counted in 0.5 dB below +48 dB
  localparam gain_t GAIN_MUTE  = 8'hFF;
  localparam gain_t GAIN_UNITY = 8'd96;

  typedef struct packed {
    logic zd_en;
    logic soft_en;
    logic soft_mute;
    logic hard_mute;
  } mctl_t;

  typedef struct packed {
    logic bypass;
    logic soft_mute;
    logic hard_mute;
  } cctl_t;

  localparam mctl_t MCTL_RESET = 4'b0100;
  localparam gain_t CHVOL_RESET = 8'h60;

  function automatic gain_t gain_sum(input gain_t a, input gain_t b);
    logic [GAIN_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[GAIN_W] ? GAIN_MUTE : s[GAIN_W-1:0];
  endfunction

endpackage

// File: rtl/svol_regs.sv
module svol_regs
  import svol_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wdata,
  output gain_t                 master_vol,
  output mctl_t                 mctl,
  output gain_t [NCH-1:0]       ch_vol,
  output cctl_t [NCH-1:0]       cctl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_vol <= '0;
      mctl       <= MCTL_RESET;
    end else if (wr) begin
      if (addr == ADDR_W'(0)) master_vol <= wdata;
      if (addr == ADDR_W'(1)) mctl       <= mctl_t'(wdata[3:0]);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] VOL_A = ADDR_W'(2 + c);
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(2 + NCH + c);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_vol[c] <= CHVOL_RESET;
        cctl[c]   <= '0;
      end else if (wr) begin
        if (addr == VOL_A) ch_vol[c] <= wdata;
        if (addr == CTL_A) cctl[c]   <= cctl_t'(wdata[2:0]);
      end
    end
  end

endmodule

// File: rtl/svol_ramp.sv
module svol_ramp
  import svol_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  gain_t target,
  input  logic  hard,
  input  logic  jump,
  input  logic  tick,
  output gain_t level
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      level <= GAIN_MUTE;
    else if (hard)
      level <= GAIN_MUTE;
    else if (jump)
      level <= target;
    else if (tick && level != target)
      level <= (level < target) ? level + gain_t'(1) : level - gain_t'(1);
  end

endmodule

// File: rtl/svol_zdet.sv
module svol_zdet #(
  parameter int ZD_LEN = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic acc,
  input  logic is_zero,
  output logic mute
);

  localparam int ZW = $clog2(ZD_LEN + 1);
  localparam logic [ZW-1:0] LIMIT = ZW'(ZD_LEN);

  logic [ZW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run <= '0;
    else if (acc) begin
      if (!is_zero)
        run <= '0;
      else if (run != LIMIT)
        run <= run + ZW'(1);
    end
  end

  assign mute = en && (run == LIMIT);

endmodule

// File: rtl/svol_scale.sv
module svol_scale #(
  parameter int SAMPLE_W  = 16,
  parameter int COEF_W    = 24,
  parameter int COEF_FRAC = 16
) (
  input  logic signed [SAMPLE_W-1:0] din,
  input  logic        [COEF_W-1:0]   coef,
  input  logic                       muted,
  output logic signed [SAMPLE_W-1:0] dout
);

  localparam int PW = SAMPLE_W + COEF_W + 1;
  localparam logic signed [PW-1:0] HI = PW'((64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] LO = -HI - PW'(1);

  logic signed [PW-1:0] dext, cext, prod, shr;

  always_comb begin
    dext = PW'(din);
    cext = $signed(PW'({1'b0, coef}));
    prod = dext * cext;
    shr  = prod >>> COEF_FRAC;
    if (muted)
      dout = '0;
    else if (shr > HI)
      dout = HI[SAMPLE_W-1:0];
    else if (shr < LO)
      dout = LO[SAMPLE_W-1:0];
    else
      dout = shr[SAMPLE_W-1:0];
  end

endmodule

// File: rtl/svol_top.sv
module svol_top
  import svol_pkg::*;
#(
  parameter int NCH       = 3,
  parameter int SAMPLE_W  = 16,
  parameter int COEF_W    = 24,
  parameter int COEF_FRAC = 16,
  parameter int STEP_DIV  = 8,
  parameter int ZD_LEN    = 2048,
  localparam int ADDR_W   = $clog2(2 + 2 * NCH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [7:0]                reg_wdata,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [NCH*SAMPLE_W-1:0]   in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [NCH*SAMPLE_W-1:0]   out_data,
  output logic [NCH*GAIN_W-1:0]     gain_idx,
  input  logic [NCH*COEF_W-1:0]     lut_coef
);

  localparam int PSC_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [PSC_W-1:0] PSC_LAST = PSC_W'(STEP_DIV - 1);

  gain_t              master_vol;
  mctl_t              mctl;
  gain_t [NCH-1:0]    ch_vol;
  cctl_t [NCH-1:0]    cctl;
  gain_t [NCH-1:0]    target;
  gain_t [NCH-1:0]    applied;
  logic  [NCH-1:0]    hard;
  logic  [NCH-1:0]    jump;
  logic  [NCH-1:0]    zd_mute;
  logic  [NCH*SAMPLE_W-1:0] scaled;

  logic             accept;
  logic             tick;
  logic [PSC_W-1:0] psc;

  svol_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .master_vol (master_vol),
    .mctl       (mctl),
    .ch_vol     (ch_vol),
    .cctl       (cctl)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign tick     = accept && (psc == PSC_LAST);

  // one ramp step per STEP_DIV accepted frames, shared by all channels
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      psc <= '0;
    else if (accept)
      psc <= tick ? '0 : psc + PSC_W'(1);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [SAMPLE_W-1:0] smp;
    logic signed [SAMPLE_W-1:0] res;
    gain_t                      base;

    assign smp  = in_data[c*SAMPLE_W +: SAMPLE_W];
    assign base = cctl[c].bypass ? GAIN_UNITY : gain_sum(master_vol, ch_vol[c]);
    assign target[c] = (mctl.soft_mute || cctl[c].soft_mute) ? GAIN_MUTE : base;
    assign hard[c]   = mctl.hard_mute || cctl[c].hard_mute || zd_mute[c];
    assign jump[c]   = !mctl.soft_en || cctl[c].bypass;

    svol_zdet #(.ZD_LEN(ZD_LEN)) u_zdet (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (mctl.zd_en),
      .acc     (accept),
      .is_zero (smp == '0),
      .mute    (zd_mute[c])
    );

    svol_ramp u_ramp (
      .clk    (clk),
      .rst_n  (rst_n),
      .target (target[c]),
      .hard   (hard[c]),
      .jump   (jump[c]),
      .tick   (tick),
      .level  (applied[c])
    );

    svol_scale #(
      .SAMPLE_W  (SAMPLE_W),
      .COEF_W    (COEF_W),
      .COEF_FRAC (COEF_FRAC)
    ) u_scale (
      .din   (smp),
      .coef  (lut_coef[c*COEF_W +: COEF_W]),
      .muted (applied[c] == GAIN_MUTE),
      .dout  (res)
    );

    assign scaled[c*SAMPLE_W +: SAMPLE_W] = res;
  end

  assign gain_idx = applied;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= scaled;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/svol_chk.sv
module svol_chk #(
  parameter int NCH      = 3,
  parameter int SAMPLE_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NCH-1:0]          hard,
  input logic [NCH-1:0]          jump,
  input logic [NCH*8-1:0]        target,
  input logic [NCH*8-1:0]        level,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [NCH*SAMPLE_W-1:0] out_data
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    a_r5_hard_forces_mute: assert property (@(posedge clk) disable iff (!rst_n)
      hard[c] |=> level[c*8 +: 8] == 8'hFF);

    a_r4_jump_to_target: assert property (@(posedge clk) disable iff (!rst_n)
      (jump[c] && !hard[c]) |=> level[c*8 +: 8] == $past(target[c*8 +: 8]));

    a_r3_single_step_toward_target: assert property (@(posedge clk) disable iff (!rst_n)
      (!jump[c] && !hard[c]) |=>
        (level[c*8 +: 8] == $past(level[c*8 +: 8])) ||
        ((level[c*8 +: 8] == $past(level[c*8 +: 8]) + 1) &&
         ($past(target[c*8 +: 8]) > $past(level[c*8 +: 8]))) ||
        ((level[c*8 +: 8] + 1 == $past(level[c*8 +: 8])) &&
         ($past(target[c*8 +: 8]) < $past(level[c*8 +: 8]))));

    a_r6_mute_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && level[c*8 +: 8] == 8'hFF) |=>
        out_data[c*SAMPLE_W +: SAMPLE_W] == '0);
  end

  a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind svol_top svol_chk #(.NCH(NCH), .SAMPLE_W(SAMPLE_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hard      (hard),
  .jump      (jump),
  .target    (target),
  .level     (applied),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/test_svol_top.sv
module test_svol_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int SW  = 16;
  localparam int CW  = 24;
  localparam int FR  = 16;
  localparam int DIV = 2;
  localparam int ZD  = 8;
  localparam int AW  = $clog2(2 + 2 * NCH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [NCH*SW-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [NCH*SW-1:0] out_data;
  logic [NCH*8-1:0] gain_idx;
  logic [NCH*CW-1:0] lut_coef;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  svol_top #(
    .NCH(NCH), .SAMPLE_W(SW), .COEF_W(CW), .COEF_FRAC(FR),
    .STEP_DIV(DIV), .ZD_LEN(ZD)
  ) i_svol_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .gain_idx(gain_idx), .lut_coef(lut_coef)
  );

  // arbitrary lookup, nonzero even at the mute index
  function automatic logic [CW-1:0] lut_f(input logic [7:0] i);
    return CW'((255 - int'(i)) * 1024 + 7);
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_lut
    assign lut_coef[c*CW +: CW] = lut_f(gain_idx[c*8 +: 8]);
  end

  // requirement-level model
  int m_vol, m_ctl, psc;
  int c_vol[NCH], c_ctl[NCH], idx[NCH], zc[NCH];
  logic [NCH*SW-1:0] exp_q[$];

  function automatic int tgt(input int c);
    int b;
    b = (c_ctl[c] & 4) != 0 ? 96 : ((m_vol + c_vol[c] > 255) ? 255 : m_vol + c_vol[c]);
    if ((m_ctl & 2) != 0 || (c_ctl[c] & 2) != 0) b = 255;
    return b;
  endfunction

  function automatic bit hardm(input int c);
    return (m_ctl & 1) != 0 || (c_ctl[c] & 1) != 0 || ((m_ctl & 8) != 0 && zc[c] == ZD);
  endfunction

  function automatic bit jmp(input int c);
    return (m_ctl & 4) == 0 || (c_ctl[c] & 4) != 0;
  endfunction

  function automatic void settle();
    for (int c = 0; c < NCH; c++) begin
      if (hardm(c)) idx[c] = 255;
      else if (jmp(c)) idx[c] = tgt(c);
    end
  endfunction

  function automatic logic [SW-1:0] scale_f(input logic [SW-1:0] raw, input int i);
    longint p, hi;
    if (i == 255) return '0;
    hi = (longint'(1) <<< (SW - 1)) - 1;
    p = longint'($signed(raw)) * longint'(lut_f(8'(i)));
    p = p >>> FR;
    if (p > hi) p = hi;
    if (p < -hi - 1) p = -hi - 1;
    return SW'(p);
  endfunction

  function automatic logic [NCH*SW-1:0] mk(input int a0, input int a1, input int a2);
    return {SW'(a2), SW'(a1), SW'(a0)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_gain(input string tag);
    for (int c = 0; c < NCH; c++)
      check(gain_idx[c*8 +: 8] == 8'(idx[c]), tag, 64'(gain_idx[c*8 +: 8]), 64'(idx[c]));
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 0) m_vol = d;
    else if (a == 1) m_ctl = d & 15;
    else if (a < 2 + NCH) c_vol[a-2] = d;
    else c_ctl[a-2-NCH] = d & 7;
    settle();
    @(negedge clk);
  endtask

  // driver: waits for acceptance, pushes the expected frame, leaves one idle cycle
  task automatic send(input logic [NCH*SW-1:0] d);
    logic rdy;
    logic [NCH*SW-1:0] e;
    bit tk;
    bit h[NCH];
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    forever begin
      rdy = in_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    tk = (psc == DIV - 1);
    psc = tk ? 0 : psc + 1;
    for (int c = 0; c < NCH; c++) begin
      h[c] = hardm(c);
      e[c*SW +: SW] = scale_f(d[c*SW +: SW], idx[c]);
    end
    exp_q.push_back(e);
    for (int c = 0; c < NCH; c++) begin
      if (h[c]) idx[c] = 255;
      else if (jmp(c)) idx[c] = tgt(c);
      else if (tk && idx[c] != tgt(c)) idx[c] = (idx[c] < tgt(c)) ? idx[c] + 1 : idx[c] - 1;
    end
    for (int c = 0; c < NCH; c++)
      zc[c] = (d[c*SW +: SW] == '0) ? ((zc[c] < ZD) ? zc[c] + 1 : ZD) : 0;
    settle();
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: scoreboard comparison at each output transfer (R8, R9)
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0)
        check(1'b0, "R9 unexpected output frame", 64'(out_data), 64'd0);
      else begin
        logic [NCH*SW-1:0] e;
        e = exp_q.pop_front();
        check(out_data == e, "R8 scaled frame", 64'(out_data), 64'(e));
      end
    end
  end

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int prev;
    logic [NCH*SW-1:0] held;
    m_vol = 0; m_ctl = 4; psc = 0;
    for (int c = 0; c < NCH; c++) begin
      c_vol[c] = 96; c_ctl[c] = 0; idx[c] = 255; zc[c] = 0;
    end
    repeat (3) @(negedge clk);
    check(gain_idx == {NCH{8'hFF}}, "R10 reset index", 64'(gain_idx), 64'hFFFFFF);
    check(out_valid == 1'b0, "R10 reset out_valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(gain_idx == {NCH{8'hFF}}, "R10 index after reset", 64'(gain_idx), 64'hFFFFFF);
    check(in_ready == 1'b1, "R9 ready when empty", 64'(in_ready), 64'd1);

    // R3: power-up ramp 255 -> 96 with soft ramping on
    prev = 255;
    for (int k = 0; k < 318; k++) begin
      send(mk(k * 301 - 7000, -k * 53, k + 1));
      check((prev - int'(gain_idx[7:0])) inside {0, 1}, "R3 monotonic ramp",
            64'(gain_idx[7:0]), 64'(prev));
      prev = int'(gain_idx[7:0]);
      chk_gain("R3 ramp index");
    end
    check(gain_idx[7:0] == 8'd96, "R3 final target", 64'(gain_idx[7:0]), 64'd96);

    // R1/R2/R4: soft off, sums and saturation
    wr(1, 0);
    wr(2, 100);
    check(gain_idx[7:0] == 8'd100, "R1 channel register / R4 jump", 64'(gain_idx[7:0]), 64'd100);
    wr(0, 20);
    check(gain_idx[7:0] == 8'd120, "R2 sum", 64'(gain_idx[7:0]), 64'd120);
    check(gain_idx[15:8] == 8'd116, "R2 sum ch1", 64'(gain_idx[15:8]), 64'd116);
    wr(0, 200);
    check(gain_idx[7:0] == 8'hFF, "R2 saturated sum", 64'(gain_idx[7:0]), 64'hFF);
    wr(4, 50);
    check(gain_idx[23:16] == 8'd250, "R2 sum ch2", 64'(gain_idx[23:16]), 64'd250);

    // R4: bypass overrides volumes, jumps even with ramping on
    wr(6, 4);
    check(gain_idx[15:8] == 8'd96, "R4 bypass unity", 64'(gain_idx[15:8]), 64'd96);
    wr(1, 4);
    check(gain_idx[15:8] == 8'd96, "R4 bypass with soft on", 64'(gain_idx[15:8]), 64'd96);
    chk_gain("R4 state");

    // R8: saturation at maximum gain
    wr(1, 0); wr(0, 0); wr(2, 0); wr(6, 0);
    chk_gain("R2 after rewrite");
    send(mk(20000, -1200, 1000));
    check(out_data[15:0] == 16'h7FFF, "R8 positive saturation", 64'(out_data[15:0]), 64'h7FFF);
    send(mk(-20000, 3000, -777));
    check(out_data[15:0] == 16'h8000, "R8 negative saturation", 64'(out_data[15:0]), 64'h8000);

    // R5: hard mute with ramping on, then ramp up from mute
    wr(1, 4);
    wr(7, 1);
    check(gain_idx[23:16] == 8'hFF, "R5 hard mute", 64'(gain_idx[23:16]), 64'hFF);
    send(mk(100, 200, 5000));
    check(out_data[47:32] == 16'd0, "R5 muted output", 64'(out_data[47:32]), 64'd0);
    wr(7, 0);
    for (int k = 0; k < 4; k++) begin
      send(mk(111, 222, 333 + k));
      chk_gain("R5 ramp after release");
    end
    check(gain_idx[23:16] == 8'd253, "R5 two steps up", 64'(gain_idx[23:16]), 64'd253);

    // R6: soft mute ramps down to 255, then zero output
    wr(1, 0); wr(2, 240); wr(3, 240); wr(4, 240);
    chk_gain("R4 jump to 240");
    wr(1, 6);
    prev = int'(gain_idx[7:0]);
    for (int k = 0; k < 30; k++) begin
      send(mk(20000, -20000, 15000));
      check((int'(gain_idx[7:0]) - prev) inside {0, 1}, "R6 monotonic fade",
            64'(gain_idx[7:0]), 64'(prev));
      prev = int'(gain_idx[7:0]);
      chk_gain("R6 fade index");
    end
    check(gain_idx == {NCH{8'hFF}}, "R6 reached mute", 64'(gain_idx), 64'hFFFFFF);
    check(out_data == '0, "R6 zero at mute", 64'(out_data), 64'd0);

    // R7: zero-run mute
    wr(1, 8); wr(2, 96); wr(3, 96); wr(4, 96);
    chk_gain("R7 setup");
    for (int k = 0; k < ZD - 1; k++) send(mk(0, 400, 300));
    check(gain_idx[7:0] == 8'd96, "R7 not yet muted", 64'(gain_idx[7:0]), 64'd96);
    send(mk(0, 400, 300));
    check(gain_idx[7:0] == 8'hFF, "R7 muted after run", 64'(gain_idx[7:0]), 64'hFF);
    check(gain_idx[15:8] == 8'd96, "R7 other channel unaffected", 64'(gain_idx[15:8]), 64'd96);
    send(mk(1234, 400, 300));
    check(out_data[15:0] == 16'd0, "R7 releasing sample zero", 64'(out_data[15:0]), 64'd0);
    check(gain_idx[7:0] == 8'd96, "R7 released", 64'(gain_idx[7:0]), 64'd96);

    // R9: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    send(mk(500, 600, 700));
    held = out_data;
    check(out_valid == 1'b1, "R9 valid held", 64'(out_valid), 64'd1);
    check(in_ready == 1'b0, "R9 not ready when full", 64'(in_ready), 64'd0);
    repeat (3) @(negedge clk);
    check(out_data == held, "R9 data stable", 64'(out_data), 64'(held));
    fork
      begin
        repeat (3) @(posedge clk);
        #1 out_ready = 1'b1;
      end
      send(mk(-500, -600, -700));
    join
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 all frames delivered", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule